// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked on-chip master read and write an external asynchronous static RAM of 128K bytes that has a shared data bus. The master raises a request with a read/write flag, a 17-bit word address and a byte of write data. The controller then runs one memory access and returns a single-cycle completion pulse. On a read, the byte fetched from the memory is also returned.

On the memory side the controller drives an active-low and an active-high chip select, write enable, output enable and the address. It also drives the outgoing data byte together with a driver-enable that the pad ring uses to control the tri-state buffer; the incoming byte arrives on a separate input. Every memory timing minimum is a nanosecond parameter. Each one is turned into a whole number of clock cycles by rounding up against the clock period parameter, with at least one cycle per interval.

A write is split into two phases. In the first, write enable is already low but the controller does not drive the bus, so the memory has time to release it. In the second, the controller drives the data for at least the setup time. Output enable is never low during a write, so the two sides never drive the bus in the same cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and in every idle cycle, the memory is deselected: active-low select high, active-high select low, write enable high, output enable high, bus driver-enable low. Done is low and the read-data output is zero after reset.
- R2: A request is taken in an idle cycle when `req_i` is 1, with `we_i`=1 for a write and 0 for a read. The address is latched at that edge and held on `mem_addr_o` while either select is active. Write enable or output enable is low only while both selects are active.
- R3: A read holds both selects active, write enable high and output enable low for N_RD = max(ceil(tRC/P), ceil(tAA/P), ceil(tOE/P)) cycles, where P is the clock period. At the defaults (8 ns, 55/55/30 ns) this is 7 cycles.
- R4: Read data is sampled from `mem_dq_i` at the clock edge that ends the last read cycle. It appears on `rdata_o` in the done cycle and holds until the next read completes.
- R5: A write holds write enable low, with both selects active and output enable high, for N_WSET + N_WDAT cycles: 3 + 4 = 7 at the defaults.
- R6: The bus driver-enable rises only after write enable has been low for N_WSET = max(ceil(tWHZ/P), ceil(tOHZ/P)) cycles (3 at the defaults). The write byte is then held constant and driven for the rest of the low phase and for exactly one cycle after write enable rises.
- R7: The write-enable pulse meets the write-pulse minimum (40 ns), and the data is driven for at least the data setup minimum (25 ns) before write enable rises. N_WDAT = max(ceil(tDW/P), ceil(tWP/P) - N_WSET, ceil(tAW/P) - N_WSET, ceil(tWC/P) - N_WSET - 1, 1).
- R8: Done is high for exactly one cycle, with the memory deselected, in the cycle after the access ends. Counted in cycles after the accepting edge, done is high in cycle N_RD + 1 for a read (8 at the defaults) and in cycle N_WSET + N_WDAT + 2 for a write (9 at the defaults).
- R9: A request raised while an access or its done cycle is in progress is ignored. It starts no access, produces no done pulse and changes no stored data.
- R10: The controller's bus driver is never enabled while output enable is low. It is never enabled while the memory may still be driving the bus after a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, sampled in idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Word address |
| wdata_i | input | 8 | Write byte |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last byte read |
| mem_addr_o | output | 17 | Memory address |
| mem_cs_n_o | output | 1 | Chip select, active low |
| mem_cs_o | output | 1 | Chip select, active high |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | 8 | Outgoing data byte to the pad |
| mem_dq_oe_o | output | 1 | Pad driver enable |
| mem_dq_i | input | 8 | Incoming data byte from the pad |

## Verification
All results are sampled on the falling edge. Done is looked for in the eighth cycle after the accepting edge for a read and in the ninth for a write. The bench counts falling edges from that edge and compares the count with values it derives from the nanosecond minimums. The read byte is checked in the same cycle as done, and the absence of done is checked one cycle later. The behavioural memory returns valid data only after output enable has been low for ceil(55/8) sampled cycles, so a shortened read returns corrupted data. It measures the write-enable low time, the driver-enable start and release cycles, and the time the data is stable, each against the cycle counts in the requirements. It also holds its own outputs for three cycles after a read and flags any cycle in which both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WSET,
        ST_WDAT,
        ST_WREC,
        ST_DONE
    } phase_e;

    // Whole clock cycles covering a nanosecond minimum, never fewer than one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_o = (cnt_q == '0);

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DATA_W-1:0] d_i,
    output logic [DATA_W-1:0] q_o
);

    logic [DATA_W-1:0] q_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '0;
        end else if (en_i) begin
            q_q <= d_i;
        end
    end

    assign q_o = q_q;

endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 8,
    parameter int T_RC_NS       = 55,
    parameter int T_AA_NS       = 55,
    parameter int T_OE_NS       = 30,
    parameter int T_WC_NS       = 55,
    parameter int T_WP_NS       = 40,
    parameter int T_AW_NS       = 50,
    parameter int T_DW_NS       = 25,
    parameter int T_WHZ_NS      = 20,
    parameter int T_OHZ_NS      = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_cs_n_o,
    output logic              mem_cs_o,
    output logic              mem_we_n_o,
    output logic              mem_oe_n_o,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic              mem_dq_oe_o,
    input  logic [DATA_W-1:0] mem_dq_i
);

    // Cycle counts derived from the nanosecond minimums.
    localparam int N_RD   = max2(max2(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                                 ns_to_cyc(T_OE_NS, CLK_PERIOD_NS));
    localparam int N_WSET = max2(ns_to_cyc(T_WHZ_NS, CLK_PERIOD_NS),
                                 ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS));
    localparam int N_WDAT = max2(max2(max2(ns_to_cyc(T_DW_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_WP_NS, CLK_PERIOD_NS) - N_WSET),
                                      max2(ns_to_cyc(T_AW_NS, CLK_PERIOD_NS) - N_WSET,
                                           ns_to_cyc(T_WC_NS, CLK_PERIOD_NS) - N_WSET - 1)),
                                 1);
    localparam int N_MAX  = max2(max2(N_RD, N_WSET), N_WDAT);
    localparam int CNT_W  = $clog2(N_MAX + 1);

    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] LD_WSET = CNT_W'(N_WSET - 1);
    localparam logic [CNT_W-1:0] LD_WDAT = CNT_W'(N_WDAT - 1);

    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              cs;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic              done;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        ph:    ST_IDLE,
        addr:  '0,
        wdata: '0,
        cs_n:  1'b1,
        cs:    1'b0,
        we_n:  1'b1,
        oe_n:  1'b1,
        drv:   1'b0,
        done:  1'b0
    };

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_last;
    logic             cap_en;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .last_o (tmr_last)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) i_capture (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (cap_en),
        .d_i   (mem_dq_i),
        .q_o   (rdata_o)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        cap_en     = 1'b0;
        case (ctl_q.ph)
            ST_IDLE: begin
                if (req_i) begin
                    ctl_d.addr  = addr_i;
                    ctl_d.wdata = wdata_i;
                    ctl_d.cs_n  = 1'b0;
                    ctl_d.cs    = 1'b1;
                    tmr_load    = 1'b1;
                    if (we_i) begin
                        ctl_d.ph   = ST_WSET;
                        ctl_d.we_n = 1'b0;
                        tmr_val    = LD_WSET;
                    end else begin
                        ctl_d.ph   = ST_READ;
                        ctl_d.oe_n = 1'b0;
                        tmr_val    = LD_RD;
                    end
                end
            end
            ST_READ: begin
                if (tmr_last) begin
                    cap_en     = 1'b1;
                    ctl_d.ph   = ST_DONE;
                    ctl_d.oe_n = 1'b1;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.cs   = 1'b0;
                    ctl_d.done = 1'b1;
                end
            end
            ST_WSET: begin
                // Memory has released the bus; start driving the write byte.
                if (tmr_last) begin
                    ctl_d.ph  = ST_WDAT;
                    ctl_d.drv = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = LD_WDAT;
                end
            end
            ST_WDAT: begin
                if (tmr_last) begin
                    ctl_d.ph   = ST_WREC;
                    ctl_d.we_n = 1'b1;
                end
            end
            ST_WREC: begin
                ctl_d.ph   = ST_DONE;
                ctl_d.drv  = 1'b0;
                ctl_d.cs_n = 1'b1;
                ctl_d.cs   = 1'b0;
                ctl_d.done = 1'b1;
            end
            ST_DONE: begin
                ctl_d.ph = ST_IDLE;
            end
            default: begin
                ctl_d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign done_o      = ctl_q.done;
    assign mem_addr_o  = ctl_q.addr;
    assign mem_cs_n_o  = ctl_q.cs_n;
    assign mem_cs_o    = ctl_q.cs;
    assign mem_we_n_o  = ctl_q.we_n;
    assign mem_oe_n_o  = ctl_q.oe_n;
    assign mem_dq_o    = ctl_q.wdata;
    assign mem_dq_oe_o = ctl_q.drv;

endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 17,
    parameter int N_RD   = 7,
    parameter int N_WSET = 3,
    parameter int N_WDAT = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_cs_n_o,
    input logic              mem_cs_o,
    input logic              mem_we_n_o,
    input logic              mem_oe_n_o,
    input logic              mem_dq_oe_o
);

    logic [15:0] we_low_cnt;
    logic [15:0] oe_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_low_cnt <= '0;
        end else begin
            if (!mem_we_n_o) begin
                if (we_low_cnt != '1) we_low_cnt <= we_low_cnt + 1'b1;
            end else begin
                we_low_cnt <= '0;
            end
            if (!mem_oe_n_o) begin
                if (oe_low_cnt != '1) oe_low_cnt <= oe_low_cnt + 1'b1;
            end else begin
                oe_low_cnt <= '0;
            end
        end
    end

    AST_DONE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mem_cs_n_o && !mem_cs_o && mem_we_n_o && mem_oe_n_o)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_STROBE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n_o || !mem_oe_n_o) |-> (!mem_cs_n_o && mem_cs_o)); // R2
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o)); // R2
    AST_READ_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n_o) |-> (oe_low_cnt == 16'(N_RD))); // R3
    AST_WRITE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> (we_low_cnt == 16'(N_WSET + N_WDAT))); // R5
    AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n_o |-> mem_oe_n_o); // R5
    AST_DRV_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe_o) |-> (!mem_we_n_o && we_low_cnt == 16'(N_WSET))); // R6
    AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |-> mem_dq_oe_o); // R6
    AST_DRV_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n_o) |=> !mem_dq_oe_o); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe_o |-> mem_oe_n_o); // R10

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .N_RD   (N_RD),
    .N_WSET (N_WSET),
    .N_WDAT (N_WDAT)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_o      (done_o),
    .mem_addr_o  (mem_addr_o),
    .mem_cs_n_o  (mem_cs_n_o),
    .mem_cs_o    (mem_cs_o),
    .mem_we_n_o  (mem_we_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .mem_dq_oe_o (mem_dq_oe_o)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;

    function automatic int cdiv(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Expectations from the requirements at 8 ns and the default minimums.
    localparam int P          = 8;
    localparam int E_RD       = cdiv(55, P);                       // 7
    localparam int E_WSET     = cdiv(20, P);                       // 3
    localparam int E_WDAT     = (cdiv(25, P) > cdiv(50, P) - E_WSET)
                                ? cdiv(25, P) : cdiv(50, P) - E_WSET; // 4
    localparam int E_WLEN     = E_WSET + E_WDAT;                   // 7
    localparam int E_RD_LAT   = E_RD + 1;                          // 8
    localparam int E_WR_LAT   = E_WLEN + 2;                        // 9
    localparam int HZ_TAIL    = cdiv(20, P);                       // 3

    typedef struct packed {
        logic        wr;
        logic [16:0] addr;
        logic [7:0]  data;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 17'h00000, 8'hA5},
        '{1'b1, 17'h1FFFF, 8'h3C},
        '{1'b1, 17'h0AAAA, 8'hF0},
        '{1'b0, 17'h00000, 8'hA5},
        '{1'b0, 17'h1FFFF, 8'h3C},
        '{1'b1, 17'h00000, 8'h5A},
        '{1'b0, 17'h00000, 8'h5A},
        '{1'b0, 17'h0AAAA, 8'hF0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        done;
    logic [7:0]  rdata;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_o;
    logic [7:0]  mem_dq_i = 8'h00;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    sram_async_ctrl i_sram_async_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req),
        .we_i        (we),
        .addr_i      (addr),
        .wdata_i     (wdata),
        .done_o      (done),
        .rdata_o     (rdata),
        .mem_addr_o  (mem_addr),
        .mem_cs_n_o  (mem_cs_n),
        .mem_cs_o    (mem_cs),
        .mem_we_n_o  (mem_we_n),
        .mem_oe_n_o  (mem_oe_n),
        .mem_dq_o    (mem_dq_o),
        .mem_dq_oe_o (mem_dq_oe),
        .mem_dq_i    (mem_dq_i)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // ---------------- behavioural memory model ----------------
    logic [7:0] mem_m [logic [16:0]];
    int         r_age = 0;
    int         hz_tail = 0;
    int         w_len = 0;
    int         dw_len = 0;
    int         contention = 0;
    logic [7:0] w_dat = '0;
    logic [16:0] w_addr = '0;
    logic       drv_seen = 1'b0;
    logic       rel_pending = 1'b0;

    function automatic logic [7:0] lookup(input logic [16:0] a);
        return mem_m.exists(a) ? mem_m[a] : 8'hFF;
    endfunction

    always @(negedge clk) begin
        logic rcond, wcond, mdrv;
        if (rst_n) begin
            rcond = !mem_cs_n && mem_cs && mem_we_n && !mem_oe_n;
            wcond = !mem_cs_n && mem_cs && !mem_we_n;
            mdrv  = rcond || (hz_tail > 0);
            if (mem_dq_oe && mdrv) begin
                contention++;
                $display("FAIL R10: both sides drive bus, actual 1 expected 0 at %0t", $time);
            end
            // read side
            if (rcond) begin
                r_age++;
                mem_dq_i <= (r_age >= E_RD) ? lookup(mem_addr) : ~lookup(mem_addr);
                hz_tail  = HZ_TAIL;
            end else begin
                if (r_age != 0) chk(r_age == E_RD, "R3 read strobe cycles", r_age, E_RD);
                r_age    = 0;
                mem_dq_i <= 8'h00;
                if (hz_tail > 0) hz_tail--;
            end
            // release one cycle after write enable rises
            if (rel_pending) begin
                chk(!mem_dq_oe, "R6 driver released", int'(mem_dq_oe), 0);
                rel_pending = 1'b0;
            end
            // write side
            if (wcond) begin
                if (w_len > 0) chk(mem_addr == w_addr, "R2 address held", int'(mem_addr), int'(w_addr));
                w_addr = mem_addr;
                w_len++;
                if (mem_dq_oe) begin
                    if (!drv_seen) begin
                        drv_seen = 1'b1;
                        chk(w_len - 1 == E_WSET, "R6 we low before drive", w_len - 1, E_WSET);
                    end
                    if (dw_len > 0 && mem_dq_o == w_dat) dw_len++;
                    else dw_len = 1;
                    w_dat = mem_dq_o;
                end else if (drv_seen) begin
                    dw_len = 0;
                end
            end else if (w_len != 0) begin
                chk(w_len == E_WLEN, "R5 we low cycles", w_len, E_WLEN);
                chk(w_len * P >= 40, "R7 write pulse ns", w_len * P, 40);
                chk(dw_len * P >= 25, "R7 data setup ns", dw_len * P, 25);
                chk(mem_dq_oe, "R6 driver held after we rise", int'(mem_dq_oe), 1);
                mem_m[w_addr] = w_dat;
                rel_pending   = 1'b1;
                w_len    = 0;
                dw_len   = 0;
                drv_seen = 1'b0;
            end
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles >= 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            summary_and_end();
        end
    end

    task automatic do_access(input logic wr, input logic [16:0] a, input logic [7:0] d, output int lat);
        @(negedge clk);
        req = 1'b1; we = wr; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_idle(input string tag);
        chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe,
            tag, {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    endtask

    initial begin
        int lat;
        int dn;
        int sel;
        // R1: reset state
        repeat (3) @(negedge clk);
        check_idle("R1 outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle after reset");
        chk(!done, "R1 done low", int'(done), 0);
        chk(rdata == 8'h00, "R1 rdata zero", int'(rdata), 0);

        // Table-driven accesses
        for (int i = 0; i < NV; i++) begin
            do_access(VEC[i].wr, VEC[i].addr, VEC[i].data, lat);
            if (VEC[i].wr) begin
                chk(lat == E_WR_LAT, "R8 write latency", lat, E_WR_LAT);
            end else begin
                chk(lat == E_RD_LAT, "R8 read latency", lat, E_RD_LAT);
                chk(rdata == VEC[i].data, "R4 read data", int'(rdata), int'(VEC[i].data));
            end
            check_idle("R8 deselected in done cycle");
            @(negedge clk);
            chk(!done, "R8 done single cycle", int'(done), 0);
            check_idle("R1 idle after access");
            if (!VEC[i].wr)
                chk(rdata == VEC[i].data, "R4 rdata held", int'(rdata), int'(VEC[i].data));
        end

        // R9: requests raised while busy are ignored
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 17'h00100; wdata = 8'h77;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = 17'h00100; wdata = 8'h11;
        lat = 0;
        while (!done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        // still high during the done cycle: must also be ignored
        @(negedge clk);
        req = 1'b0;
        dn = 0;
        sel = 0;
        for (int k = 0; k < 12; k++) begin
            if (done) dn++;
            if (!mem_cs_n || mem_cs) sel++;
            @(negedge clk);
        end
        chk(dn == 0, "R9 no extra done", dn, 0);
        chk(sel == 0, "R9 no extra access", sel, 0);
        do_access(1'b0, 17'h00100, 8'h00, lat);
        chk(rdata == 8'h77, "R9 stored data untouched", int'(rdata), 8'h77);

        // R6/R10: read immediately followed by write at the same address
        do_access(1'b0, 17'h1FFFF, 8'h00, lat);
        chk(rdata == 8'h3C, "R4 read before turnaround", int'(rdata), 8'h3C);
        do_access(1'b1, 17'h1FFFF, 8'hC3, lat);
        chk(lat == E_WR_LAT, "R8 write after read latency", lat, E_WR_LAT);
        do_access(1'b0, 17'h1FFFF, 8'h00, lat);
        chk(rdata == 8'hC3, "R4 read after turnaround", int'(rdata), 8'hC3);

        repeat (4) @(negedge clk);
        chk(contention == 0, "R10 contention cycles", contention, 0);
        summary_and_end();
    end

endmodule